// File: doc/BRIEF.md
# Tagged Load Type Extractor

This block sits between a processor's load path and its register file and performs a tagged load. A request names a word address. The block reads the data word from a simple word-addressed memory port. Depending on a 2-bit location setting, it may also read the word directly before or directly after the data word, because that word holds the dynamic type tag. It cuts an 8-bit type ID out of the tag-holding word with a programmable right shift and a programmable clear of the word's most significant bits. It then presents the value, the type ID and a float/int flag on a one-cycle writeback port.

The location, shift, clear count and float type code are sampled when a request is accepted, so software may change them while a load is in flight. `busy` stays high from the cycle after acceptance up to and including the writeback cycle. Requests offered while `busy` is high are dropped. Memory responses may arrive after any number of wait cycles, and writeback waits until every read that the load needs has returned.

Top module: `tagged_load_unit`

## Requirements
- R1: During reset and right after it, `busy`, `mem_req` and `wb_valid` are 0.
- R2: Tag location codes are as follows. 2'b00 means the tag is in the data word. 2'b01 means the word at address minus one. 2'b10 means the word at address plus one. 2'b11 means no tag. Neighbour addresses wrap modulo 2^AW.
- R3: The type ID is bits [7:0] of the tag word after it is shifted right by `cfg_shift` and then has its top `cfg_mask` bits cleared. A clear count of DW or more gives 0.
- R4: With code 2'b11 the load issues exactly one read, and writeback carries type 0x00 with the float flag at 0.
- R5: With codes 2'b01 and 2'b10 the load issues exactly two reads: first the data address, then the neighbour address.
- R6: `wb_is_float` is 1 exactly when the load is typed (code other than 2'b11) and the type ID equals `cfg_float_type`.
- R7: With a memory that responds in the cycle after a request, `wb_valid` rises 3 cycles after the accepting edge for codes 2'b00 and 2'b11, and 4 cycles after it for 2'b01 and 2'b10.
- R8: `wb_valid` is a single-cycle pulse per load, and `wb_value` equals the data word read from the requested address.
- R9: `busy` is high from the cycle after acceptance through the writeback cycle. A request offered while busy produces no read and no writeback.
- R10: Configuration inputs are sampled at acceptance. Changing them while the load is in flight has no effect on its result.
- R11: Each cycle by which a memory response is delayed delays writeback by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_tag_loc | input | 2 | Tag location code |
| cfg_shift | input | SW | Right shift applied to the tag word |
| cfg_mask | input | MW | Number of top bits of the shifted word to clear |
| cfg_float_type | input | TAG_W | Type ID that marks a floating-point value |
| req_valid | input | 1 | Load request, taken when not busy |
| req_addr | input | AW | Word address of the value |
| busy | output | 1 | Load in flight |
| mem_req | output | 1 | Memory read request, one cycle per read |
| mem_addr | output | AW | Memory read word address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |
| wb_valid | output | 1 | Writeback strobe |
| wb_value | output | DW | Loaded value |
| wb_type | output | TAG_W | Extracted type ID, 0x00 when untyped |
| wb_is_float | output | 1 | Float/int flag |

## Verification
The bench builds the block with AW=6, DW=32 and TAG_W=8, so a 64-word behavioural memory covers the whole address space. Address 0 with the previous-word code and address 63 with the next-word code therefore exercise wraparound directly. With DW=32, every shift amount from 0 to 31 and clear counts from 0 up to and beyond the full word width can be drawn at random. The bench memory adds 0 to 2 wait cycles per response, which brings the stall behaviour and the exact latency counts into reach.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    LOC_SAME = 2'b00,
    LOC_PREV = 2'b01,
    LOC_NEXT = 2'b10,
    LOC_NONE = 2'b11
  } tag_loc_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DREQ  = 3'd1,
    ST_DWAIT = 3'd2,
    ST_TWAIT = 3'd3,
    ST_WB    = 3'd4
  } ld_state_e;

  localparam logic [7:0] UNTYPED_ID = 8'h00;

endpackage

// File: rtl/tl_tag_extract.sv
module tl_tag_extract #(
  parameter int DW    = 32,
  parameter int TAG_W = 8,
  parameter int SW    = $clog2(DW),
  parameter int MW    = $clog2(DW + 1)
) (
  input  logic [DW-1:0]    word_i,
  input  logic [SW-1:0]    shift_i,
  input  logic [MW-1:0]    clear_i,
  output logic [TAG_W-1:0] tag_o
);

  logic [DW-1:0] shifted;
  logic [DW-1:0] keep;
  logic [DW-1:0] kept;

  always_comb begin
    shifted = word_i >> shift_i;
    keep    = {DW{1'b1}} >> clear_i;
    kept    = shifted & keep;
    tag_o   = kept[TAG_W-1:0];
  end

endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
  import tl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TAG_W = 8,
  parameter int SW    = $clog2(DW),
  parameter int MW    = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       cfg_tag_loc,
  input  logic [SW-1:0]    cfg_shift,
  input  logic [MW-1:0]    cfg_mask,
  input  logic [TAG_W-1:0] cfg_float_type,
  output logic             busy,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             cap_en,
  output logic [DW-1:0]    cap_value,
  output logic             cap_typed,
  output logic [SW-1:0]    ext_shift,
  output logic [MW-1:0]    ext_mask,
  output logic [TAG_W-1:0] ext_float_type
);

  ld_state_e        state_q, state_d;
  tag_loc_e         loc_q;
  logic [AW-1:0]    addr_q;
  logic [SW-1:0]    shift_q;
  logic [MW-1:0]    mask_q;
  logic [TAG_W-1:0] ftype_q;
  logic [DW-1:0]    val_q;
  logic             accept;
  logic             val_en;
  logic             neighbour;
  logic [AW-1:0]    tag_addr;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign neighbour = (loc_q == LOC_PREV) || (loc_q == LOC_NEXT);
  assign tag_addr  = (loc_q == LOC_PREV) ? addr_q - AW'(1) : addr_q + AW'(1);

  always_comb begin
    state_d  = state_q;
    mem_req  = 1'b0;
    mem_addr = addr_q;
    cap_en   = 1'b0;
    val_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_DREQ;
      end
      ST_DREQ: begin
        mem_req = 1'b1;
        state_d = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (mem_rsp_valid) begin
          if (neighbour) begin
            val_en   = 1'b1;
            mem_req  = 1'b1;
            mem_addr = tag_addr;
            state_d  = ST_TWAIT;
          end else begin
            cap_en  = 1'b1;
            state_d = ST_WB;
          end
        end
      end
      ST_TWAIT: begin
        if (mem_rsp_valid) begin
          cap_en  = 1'b1;
          state_d = ST_WB;
        end
      end
      ST_WB: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy           = (state_q != ST_IDLE);
  assign cap_value      = (state_q == ST_TWAIT) ? val_q : mem_rsp_data;
  assign cap_typed      = (loc_q != LOC_NONE);
  assign ext_shift      = shift_q;
  assign ext_mask       = mask_q;
  assign ext_float_type = ftype_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q   <= LOC_NONE;
      addr_q  <= '0;
      shift_q <= '0;
      mask_q  <= '0;
      ftype_q <= '0;
    end else if (accept) begin
      loc_q   <= tag_loc_e'(cfg_tag_loc);
      addr_q  <= req_addr;
      shift_q <= cfg_shift;
      mask_q  <= cfg_mask;
      ftype_q <= cfg_float_type;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= mem_rsp_data;
  end

  // R10: the sampled load description never moves while a load is in flight
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(loc_q) && $stable(shift_q)
                              && $stable(mask_q) && $stable(ftype_q)));

  // R5 / R4: only neighbour-tag loads ever wait for a second response
  a_r5_second_read_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TWAIT) |-> ((loc_q == LOC_PREV) || (loc_q == LOC_NEXT)));

  // R9: a load in flight stays busy until its writeback cycle
  a_r9_busy_until_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (state_q != ST_WB)) |=> busy);

  // R9: writeback is followed by return to idle
  a_r9_wb_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/tl_wb_stage.sv
module tl_wb_stage #(
  parameter int DW    = 32,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [DW-1:0]    cap_value,
  input  logic [TAG_W-1:0] cap_tag,
  input  logic             cap_typed,
  input  logic [TAG_W-1:0] float_type,
  output logic             wb_valid,
  output logic [DW-1:0]    wb_value,
  output logic [TAG_W-1:0] wb_type,
  output logic             wb_is_float
);

  logic [TAG_W-1:0] type_d;
  logic             float_d;
  logic             typed_q;

  always_comb begin
    type_d  = cap_typed ? cap_tag : TAG_W'(tl_pkg::UNTYPED_ID);
    float_d = cap_typed && (cap_tag == float_type);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_valid <= 1'b0;
    else        wb_valid <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_value    <= '0;
      wb_type     <= '0;
      wb_is_float <= 1'b0;
      typed_q     <= 1'b0;
    end else if (cap_en) begin
      wb_value    <= cap_value;
      wb_type     <= type_d;
      wb_is_float <= float_d;
      typed_q     <= cap_typed;
    end
  end

  // R8: one strobe per load
  a_r8_wb_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R4: an untyped writeback carries the untyped code and an integer flag
  a_r4_untyped_result: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !typed_q) |-> ((wb_type == '0) && !wb_is_float));

endmodule

// File: rtl/tagged_load_unit.sv
module tagged_load_unit #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int TAG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SW          = $clog2(DW),
  parameter int MW          = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_tag_loc,
  input  logic [SW-1:0]    cfg_shift,
  input  logic [MW-1:0]    cfg_mask,
  input  logic [TAG_W-1:0] cfg_float_type,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             busy,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             wb_valid,
  output logic [DW-1:0]    wb_value,
  output logic [TAG_W-1:0] wb_type,
  output logic             wb_is_float
);

  logic rst_n_int;

  generate
    if (SYNC_STAGES > 1) begin : g_rst_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_int = sync_q[SYNC_STAGES-1];
    end else begin : g_rst_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_n_int = sync_q;
    end
  endgenerate

  logic             cap_en;
  logic [DW-1:0]    cap_value;
  logic             cap_typed;
  logic [SW-1:0]    ext_shift;
  logic [MW-1:0]    ext_mask;
  logic [TAG_W-1:0] ext_float_type;
  logic [TAG_W-1:0] cap_tag;

  tl_ctrl #(.AW(AW), .DW(DW), .TAG_W(TAG_W), .SW(SW), .MW(MW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .cfg_tag_loc    (cfg_tag_loc),
    .cfg_shift      (cfg_shift),
    .cfg_mask       (cfg_mask),
    .cfg_float_type (cfg_float_type),
    .busy           (busy),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .cap_en         (cap_en),
    .cap_value      (cap_value),
    .cap_typed      (cap_typed),
    .ext_shift      (ext_shift),
    .ext_mask       (ext_mask),
    .ext_float_type (ext_float_type)
  );

  tl_tag_extract #(.DW(DW), .TAG_W(TAG_W), .SW(SW), .MW(MW)) u_extract (
    .word_i  (mem_rsp_data),
    .shift_i (ext_shift),
    .clear_i (ext_mask),
    .tag_o   (cap_tag)
  );

  tl_wb_stage #(.DW(DW), .TAG_W(TAG_W)) u_wb (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cap_en      (cap_en),
    .cap_value   (cap_value),
    .cap_tag     (cap_tag),
    .cap_typed   (cap_typed),
    .float_type  (ext_float_type),
    .wb_valid    (wb_valid),
    .wb_value    (wb_value),
    .wb_type     (wb_type),
    .wb_is_float (wb_is_float)
  );

  // R9: reads are only issued on behalf of an accepted load
  a_r9_read_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req |-> busy);

  // R9: the writeback strobe lies inside the busy window
  a_r9_wb_inside_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    wb_valid |-> busy);

  // R1: nothing is requested or written back while reset holds
  always_ff @(posedge clk) begin
    if (!rst_n_int) begin
      a_r1_quiet_in_reset: assert (!mem_req && !wb_valid && !busy);
    end
  end

endmodule

// File: tb/tagged_load_unit_bench.sv
`timescale 1ns/1ps
module tagged_load_unit_bench;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int TW = 8;
  localparam int SW = $clog2(DW);
  localparam int MW = $clog2(DW + 1);
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cfg_tag_loc;
  logic [SW-1:0] cfg_shift;
  logic [MW-1:0] cfg_mask;
  logic [TW-1:0] cfg_float_type;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          busy;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          wb_valid;
  logic [DW-1:0] wb_value;
  logic [TW-1:0] wb_type;
  logic          wb_is_float;

  int n_checks;
  int n_fail;
  int lat;
  bit done;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] p_addr;
  int            p_cnt;

  tagged_load_unit #(.AW(AW), .DW(DW), .TAG_W(TW)) u_tagged_load_unit (
    .clk(clk), .rst_n(rst_n), .cfg_tag_loc(cfg_tag_loc), .cfg_shift(cfg_shift),
    .cfg_mask(cfg_mask), .cfg_float_type(cfg_float_type), .req_valid(req_valid),
    .req_addr(req_addr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid),
    .wb_value(wb_value), .wb_type(wb_type), .wb_is_float(wb_is_float)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural memory: responds lat cycles after the cycle following a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      p_cnt         <= 0;
      p_addr        <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req) begin
        if (lat == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_addr];
        end else begin
          p_addr <= mem_addr;
          p_cnt  <= lat;
        end
      end else if (p_cnt != 0) begin
        p_cnt <= p_cnt - 1;
        if (p_cnt == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[p_addr];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_tag(input logic [DW-1:0] w,
                                            input int sh, input int clr);
    logic [DW-1:0] s;
    logic [DW-1:0] k;
    s = w >> sh;
    k = (clr >= DW) ? '0 : ({DW{1'b1}} >> clr);
    s = s & k;
    return s[TW-1:0];
  endfunction

  task automatic do_load(input logic [AW-1:0] a, input logic [1:0] loc, input int sh,
                         input int clr, input logic [TW-1:0] ft, input int l, input bit poke);
    logic [AW-1:0] taddr;
    logic [DW-1:0] tword;
    logic [TW-1:0] et;
    bit            typed;
    bit            neigh;
    int            cyc;
    int            nrd;
    int            nwb;
    int            exp_lat;
    logic [AW-1:0] rd0;
    logic [AW-1:0] rd1;
    typed = (loc != 2'b11);
    neigh = (loc == 2'b01) || (loc == 2'b10);
    taddr = (loc == 2'b01) ? a - AW'(1) : (loc == 2'b10) ? a + AW'(1) : a;
    tword = mem[taddr];
    et    = typed ? exp_tag(tword, sh, clr) : 8'h00;
    exp_lat = neigh ? 4 + 2 * l : 3 + l;
    lat = l;
    cfg_tag_loc    = loc;
    cfg_shift      = SW'(sh);
    cfg_mask       = MW'(clr);
    cfg_float_type = ft;
    req_addr  = a;
    req_valid = 1'b1;
    cyc = 0; nrd = 0; nwb = 0; rd0 = '0; rd1 = '0;
    while (nwb == 0 && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 1);
        // R10: scramble configuration while the load is in flight
        cfg_tag_loc    = 2'($urandom);
        cfg_shift      = SW'($urandom);
        cfg_mask       = MW'($urandom);
        cfg_float_type = TW'($urandom);
        req_addr       = AW'($urandom);
        req_valid      = poke;
      end else begin
        req_valid = 1'b0;
      end
      if (mem_req) begin
        if (nrd == 0) rd0 = mem_addr;
        if (nrd == 1) rd1 = mem_addr;
        nrd++;
      end
      if (wb_valid) begin
        nwb++;
        chk(cyc == exp_lat, (l == 0) ? "R7" : "R11", "writeback latency", 32'(cyc), 32'(exp_lat));
        chk(wb_value == mem[a], "R8", "value", wb_value, mem[a]);
        chk(wb_type == et, typed ? "R3" : "R4", "type", 32'(wb_type), 32'(et));
        chk(wb_is_float == (typed && et == ft), "R6", "float flag", 32'(wb_is_float),
            32'(typed && et == ft));
        chk(busy == 1'b1, "R9", "busy at writeback", 32'(busy), 1);
      end
    end
    chk(nwb == 1, "R8", "writeback seen", 32'(nwb), 1);
    chk(nrd == (neigh ? 2 : 1), neigh ? "R5" : "R4", "read count", 32'(nrd), neigh ? 2 : 1);
    chk(rd0 == a, "R5", "first read address", 32'(rd0), 32'(a));
    if (neigh) chk(rd1 == taddr, "R2", "tag read address", 32'(rd1), 32'(taddr));
    // after writeback: idle, no stray read or writeback
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (poke || i == 0)
        chk(!busy && !wb_valid && !mem_req, "R9", "idle after load",
            {29'd0, busy, wb_valid, mem_req}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_checks = 0; n_fail = 0; done = 0; lat = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    mem[5]  = 32'hA5C3_1E7F;
    mem[0]  = 32'h1234_5678;
    mem[63] = 32'h00AB_00CD;
    mem[1]  = 32'hFFFF_0042;
    cfg_tag_loc = 2'b00; cfg_shift = '0; cfg_mask = '0; cfg_float_type = '0;
    req_valid = 1'b0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !wb_valid, "R1", "outputs in reset",
        {29'd0, busy, mem_req, wb_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req && !wb_valid, "R1", "outputs after reset",
        {29'd0, busy, mem_req, wb_valid}, 0);

    do_load(6'd5, 2'b00, 0, 24, 8'h7F, 0, 0);   // R3 low byte kept
    do_load(6'd5, 2'b00, 28, 0, 8'h00, 0, 0);   // R3 top nibble
    do_load(6'd0, 2'b01, 8, 16, 8'h12, 0, 0);   // R2 wrap to 63
    do_load(6'd63, 2'b10, 16, 8, 8'h00, 0, 0);  // R2 wrap to 0
    do_load(6'd5, 2'b11, 0, 0, 8'h00, 0, 0);    // R4 untyped
    do_load(6'd5, 2'b00, 0, 32, 8'h00, 0, 0);   // R3 full clear, R6 float code 0
    do_load(6'd1, 2'b01, 3, 40, 8'h00, 1, 1);   // R3 over-wide clear, R9 poke, R11
    do_load(6'd20, 2'b10, 4, 12, 8'h00, 2, 1);  // R11 two wait cycles per read

    for (int n = 0; n < 120; n++) begin
      logic [AW-1:0] a;
      logic [1:0]    loc;
      int            sh;
      int            clr;
      logic [AW-1:0] ta;
      logic [TW-1:0] ft;
      a   = AW'($urandom);
      loc = 2'($urandom);
      sh  = $urandom_range(0, DW - 1);
      clr = $urandom_range(0, DW + 4);
      ta  = (loc == 2'b01) ? a - AW'(1) : (loc == 2'b10) ? a + AW'(1) : a;
      ft  = ($urandom_range(0, 1) == 1) ? exp_tag(mem[ta], sh, clr) : TW'($urandom);
      do_load(a, loc, sh, clr, ft, $urandom_range(0, 2), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule